// File: doc/BRIEF.md
# Serial-Access Byte Memory with SPI Slave Front End

This block is an SPI slave that fronts a small on-chip byte memory. A controller lowers the select line, shifts in an 8-bit instruction, and for memory accesses follows it with a 16-bit address. Data bytes are then streamed in or out. The top address bit is ignored, so the pointer is 15 bits wide. All four SPI pins are oversampled by a system clock through a synchronizer. The block reacts to the synchronized SCK edges: SI is captured on a rising edge, and SO is updated after a falling edge. SO is a plain data output, with a separate enable that stands in for the high-impedance state.

A status register chooses how the pointer moves between bytes. In word mode a single byte is transferred. In page mode the pointer steps inside an aligned 32-byte page and wraps within it. In burst mode it steps through the whole 15-bit space and wraps from 7FFFh to 0000h. Another status bit turns the hold input on or off. When hold is on, lowering the hold input freezes a frame at the exact bit where it stopped. Raising it again resumes the frame from that point.

The storage is a window of 2^MEM_AW bytes. The low pointer bits index it, so a full-size part sets MEM_AW equal to ADDR_W. The frame is run by an FSM with these states:
- ST_IDLE: select is high.
- ST_CMD: 8 opcode bits.
- ST_ADDR: 16 address bits.
- ST_RDAT: read data.
- ST_RZERO: word-mode read is over; zeros are driven.
- ST_WDAT: write data.
- ST_SRD: status read.
- ST_SWR: status write.
- ST_SINK: clocks are ignored and SO is released.

Transitions:
- Select high sends any state to ST_IDLE, and select low moves ST_IDLE to ST_CMD.
- On the 8th opcode bit, ST_CMD goes to ST_ADDR (read or write), ST_SRD, ST_SWR, or ST_SINK for any other code.
- After the 16th address bit, ST_ADDR goes to ST_RDAT or ST_WDAT.
- In word mode, the first byte moves ST_RDAT to ST_RZERO and ST_WDAT to ST_SINK.
- The 8th bit of a status write moves ST_SWR to ST_SINK.

Top module: `spi_sram_slave`

## Requirements
- R1: Opcode 8'h03 followed by a 16-bit address (MSB first, bit 15 ignored) returns the byte stored at that address MSB first. Each bit is driven after an SCK falling edge and is valid before the next rising edge. SO enable is 1 during read data.
- R2: Opcode 8'h02 followed by the address stores the following bytes. Their bits are sampled MSB first on SCK rising edges.
- R3: Opcode 8'h01 writes the status byte and opcode 8'h05 reads it back MSB first, repeating for as long as clocks continue. Bits [7:6] are the mode: 00 word, 10 page, 01 burst. Bit 0 set to 1 disables hold. Bits [5:1] always read as 0. After reset the status byte is 8'h00.
- R4: In word mode, only the first data byte of a frame is written. A read returns one byte and then 8'h00 for every later byte. The pointer does not advance.
- R5: In page mode the pointer steps by one and wraps from byte 31 to byte 0 of the same 32-byte page. Bytes outside the page are untouched.
- R6: In burst mode the pointer steps by one across the whole space and wraps from 7FFFh to 0000h.
- R7: Mode code 11 is stored as written and reads back as such, but it behaves as word mode.
- R8: While CS_n is high, SO enable is 0, and raising CS_n ends the frame. A data byte cut off before its 8th bit is not written. The SO enable is 0 after reset.
- R9: With hold enabled, lowering HOLD_n while SCK is low pauses the frame at once. While paused, SO enable is 0 and SCK and SI are ignored. Raising HOLD_n with SCK low resumes the frame with no bit lost or added.
- R10: With hold enabled, lowering HOLD_n while SCK is high makes SO enable 0 at once. The pause starts at the next SCK falling edge, and that edge still advances the output bit. The frame resumes as in R9.
- R11: With status bit 0 set, HOLD_n has no effect: SO enable stays 1 and the read data is unchanged.
- R12: Any other opcode leaves SO enable at 0 for the rest of the frame, and the bytes that follow do not modify memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select; framing |
| sck | input | 1 | SPI serial clock |
| si | input | 1 | Serial data into the block |
| hold_n | input | 1 | Active-low pause request |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Output enable for so; 0 models high impedance |

## Verification
The assertions assume the SPI pins change slowly compared with clk, with every SCK phase lasting several clk cycles. They also assume HOLD_n changes only while SCK is stable, and CS_n only while SCK is low. Under those conditions the synchronized edges map one to one onto pin edges. The stimulus meets these assumptions by driving every pin on a falling clk edge and holding each SCK phase for four clk cycles. It moves HOLD_n only in the middle of a stable SCK phase. Random transactions draw the mode code, direction, address and length. Directed cases cover page and array wrap, word-mode truncation, aborted frames, unknown opcodes and both hold timings.

// File: rtl/spi_sram_pkg.sv
package spi_sram_pkg;

    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;

    typedef enum logic [1:0] {
        AM_WORD  = 2'd0,
        AM_PAGE  = 2'd1,
        AM_BURST = 2'd2
    } addr_mode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_RDAT,
        ST_RZERO,
        ST_WDAT,
        ST_SRD,
        ST_SWR,
        ST_SINK
    } spi_state_e;

    // status bits [7:6] -> pointer stepping rule; code 11 falls back to word
    function automatic addr_mode_e decode_mode(input logic [1:0] code);
        case (code)
            2'b10:   return AM_PAGE;
            2'b01:   return AM_BURST;
            default: return AM_WORD;
        endcase
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int         NPINS   = 4,
    parameter int         STAGES  = 2,
    parameter logic [3:0] RST_VAL = 4'b1001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_raw,
    output logic [NPINS-1:0] pin_s
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[i]}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pin_raw[i]};
            end
        end
        assign pin_s[i] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_s,
    input  logic hold_en,
    input  logic hold_n_s,
    input  logic sck_s,
    output logic hold_req,
    output logic paused
);

    assign hold_req = hold_en & ~hold_n_s & ~cs_n_s;

    // enter the pause only with SCK low, leave it only with SCK low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            paused <= 1'b0;
        end else if (cs_n_s) begin
            paused <= 1'b0;
        end else if (hold_req) begin
            if (!sck_s) paused <= 1'b1;
        end else if (!sck_s) begin
            paused <= 1'b0;
        end
    end

    p_pause_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paused) |-> $past(hold_req && !sck_s));

    p_resume_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(paused) |-> $past(!sck_s || cs_n_s));

endmodule

// File: rtl/spi_addr_ptr.sv
module spi_addr_ptr import spi_sram_pkg::*; #(
    parameter int ADDR_W  = 15,
    parameter int PAGE_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              adv,
    input  addr_mode_e        mode,
    output logic [ADDR_W-1:0] ptr
);

    localparam int HI_W = ADDR_W - PAGE_AW;

    logic [ADDR_W-1:0] step_val;

    always_comb begin
        unique case (mode)
            AM_PAGE:  step_val = {ptr[ADDR_W-1:PAGE_AW], ptr[PAGE_AW-1:0] + PAGE_AW'(1)};
            AM_BURST: step_val = ptr + ADDR_W'(1);
            default:  step_val = ptr;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (adv) begin
            ptr <= step_val;
        end
    end

    p_page_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && mode == AM_PAGE) |=>
            (ptr[ADDR_W-1:PAGE_AW] == $past(ptr[ADDR_W-1:PAGE_AW]) &&
             ptr[PAGE_AW-1:0] == $past(ptr[PAGE_AW-1:0]) + PAGE_AW'(1)));

    p_burst_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && mode == AM_BURST) |=> ptr == $past(ptr) + ADDR_W'(1));

    p_word_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && mode == AM_WORD) |=> $stable(ptr));

    p_page_hi_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && mode == AM_PAGE) |=> $stable(ptr[ADDR_W-1 -: HI_W]));

endmodule

// File: rtl/spi_byte_store.sv
module spi_byte_store #(
    parameter int MEM_AW = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [MEM_AW-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [MEM_AW-1:0] raddr,
    output logic [7:0]        rdata
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/spi_sram_slave.sv
module spi_sram_slave import spi_sram_pkg::*; #(
    parameter int ADDR_W      = 15,
    parameter int MEM_AW      = 9,
    parameter int PAGE_AW     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    output logic so,
    output logic so_oe
);

    localparam int         NPINS   = 4;
    localparam logic [3:0] PIN_RST = 4'b1001;

    logic [NPINS-1:0] pins_s;
    logic cs_n_s, sck_s, si_s, hold_n_s, sck_p;
    logic hold_req, paused, hold_blk;
    logic rise_ok, fall_ok;

    spi_state_e st_q, st_nxt;
    logic [3:0]        cnt_q, byte_wrap;
    logic [6:0]        sh_q;
    logic [ADDR_W-2:0] asr_q;
    logic [6:0]        tx_q;
    logic              so_q, op_rd_q;
    logic [1:0]        stat_mode_q;
    logic              stat_hold_dis_q;
    logic [7:0]        stat_byte, byte_in, rdata;
    addr_mode_e        mode;

    logic              mem_we, ptr_load, ptr_adv;
    logic [ADDR_W-1:0] load_val, ptr;

    spi_pin_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .pin_raw({hold_n, si, sck, cs_n}),
        .pin_s(pins_s)
    );

    assign cs_n_s   = pins_s[0];
    assign sck_s    = pins_s[1];
    assign si_s     = pins_s[2];
    assign hold_n_s = pins_s[3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_p <= 1'b0;
        else        sck_p <= sck_s;
    end

    spi_hold_ctrl u_hold (
        .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s),
        .hold_en(~stat_hold_dis_q), .hold_n_s(hold_n_s), .sck_s(sck_s),
        .hold_req(hold_req), .paused(paused)
    );

    assign hold_blk = paused | hold_req;
    assign rise_ok  = sck_s & ~sck_p & ~cs_n_s & ~hold_blk;
    assign fall_ok  = ~sck_s & sck_p & ~cs_n_s & ~paused;

    assign stat_byte = {stat_mode_q, 5'b00000, stat_hold_dis_q};
    assign mode      = decode_mode(stat_mode_q);
    assign byte_in   = {sh_q, si_s};
    assign load_val  = {asr_q, si_s};
    assign byte_wrap = (cnt_q[2:0] == 3'd7) ? 4'd0 : cnt_q + 4'd1;

    // next-state logic
    always_comb begin
        st_nxt = st_q;
        if (cs_n_s) begin
            st_nxt = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: st_nxt = ST_CMD;
                ST_CMD: begin
                    if (rise_ok && cnt_q == 4'd7) begin
                        case (byte_in)
                            OP_READ, OP_WRITE: st_nxt = ST_ADDR;
                            OP_RDSR:           st_nxt = ST_SRD;
                            OP_WRSR:           st_nxt = ST_SWR;
                            default:           st_nxt = ST_SINK;
                        endcase
                    end
                end
                ST_ADDR: begin
                    if (rise_ok && cnt_q == 4'd15)
                        st_nxt = op_rd_q ? ST_RDAT : ST_WDAT;
                end
                ST_RDAT: begin
                    if (fall_ok && cnt_q == 4'd7 && mode == AM_WORD) st_nxt = ST_RZERO;
                end
                ST_WDAT: begin
                    if (rise_ok && cnt_q == 4'd7 && mode == AM_WORD) st_nxt = ST_SINK;
                end
                ST_SWR: begin
                    if (rise_ok && cnt_q == 4'd7) st_nxt = ST_SINK;
                end
                default: st_nxt = st_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    // shift registers, bit counter, status register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q           <= '0;
            sh_q            <= '0;
            asr_q           <= '0;
            tx_q            <= '0;
            so_q            <= 1'b0;
            op_rd_q         <= 1'b0;
            stat_mode_q     <= 2'b00;
            stat_hold_dis_q <= 1'b0;
        end else if (cs_n_s) begin
            cnt_q <= '0;
        end else begin
            if (rise_ok) begin
                case (st_q)
                    ST_CMD, ST_WDAT, ST_SWR: begin
                        sh_q  <= byte_in[6:0];
                        cnt_q <= byte_wrap;
                    end
                    ST_ADDR: begin
                        asr_q <= load_val[ADDR_W-2:0];
                        cnt_q <= cnt_q + 4'd1;
                    end
                    default: ;
                endcase
                if (st_q == ST_CMD && cnt_q == 4'd7) op_rd_q <= (byte_in == OP_READ);
                if (st_q == ST_SWR && cnt_q == 4'd7) begin
                    stat_mode_q     <= byte_in[7:6];
                    stat_hold_dis_q <= byte_in[0];
                end
            end
            if (fall_ok) begin
                case (st_q)
                    ST_RDAT: begin
                        if (cnt_q[2:0] == 3'd0) {so_q, tx_q} <= rdata;
                        else                    {so_q, tx_q} <= {tx_q, 1'b0};
                        cnt_q <= byte_wrap;
                    end
                    ST_RZERO: so_q <= 1'b0;
                    ST_SRD: begin
                        so_q  <= stat_byte[3'd7 - cnt_q[2:0]];
                        cnt_q <= byte_wrap;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        mem_we   = rise_ok && st_q == ST_WDAT && cnt_q == 4'd7;
        ptr_load = rise_ok && st_q == ST_ADDR && cnt_q == 4'd15;
        ptr_adv  = mem_we || (fall_ok && st_q == ST_RDAT && cnt_q == 4'd7);
        so_oe    = (st_q == ST_RDAT || st_q == ST_RZERO || st_q == ST_SRD) && !hold_blk;
        so       = so_q;
    end

    spi_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(load_val),
        .adv(ptr_adv), .mode(mode), .ptr(ptr)
    );

    spi_byte_store #(.MEM_AW(MEM_AW)) u_store (
        .clk(clk), .we(mem_we), .waddr(ptr[MEM_AW-1:0]), .wdata(byte_in),
        .raddr(ptr[MEM_AW-1:0]), .rdata(rdata)
    );

    p_cs_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !so_oe);

    p_load_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ptr_load) |-> ptr == $past(load_val));

    p_pause_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(paused) && paused |-> $stable(ptr) && $stable(so));

    p_rzero_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fall_ok && st_q == ST_RZERO) |-> !so);

endmodule

// File: tb/tb_spi_sram_slave.sv
module tb_spi_sram_slave;

    localparam int HALF   = 4;
    localparam int MEM_AW = 9;
    localparam int MEMN   = 1 << MEM_AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic so, so_oe;

    always #10 clk = ~clk;

    spi_sram_slave #(.MEM_AW(MEM_AW)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .so(so), .so_oe(so_oe)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] mem_m [MEMN];
    logic [7:0] stat_m = 8'h00;
    logic [7:0] wbuf [64];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int mmode();
        case (stat_m[7:6])
            2'b10:   return 1;
            2'b01:   return 2;
            default: return 0;
        endcase
    endfunction

    function automatic logic [14:0] nxt(input logic [14:0] p);
        case (mmode())
            1:       return {p[14:5], p[4:0] + 5'd1};
            2:       return p + 15'd1;
            default: return p;
        endcase
    endfunction

    task automatic waith();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic pulses();
        for (int k = 0; k < 3; k++) begin
            si = $urandom % 2;
            waith();
            sck = 1'b1;
            waith();
            sck = 1'b0;
        end
        waith();
    endtask

    // kind: 0 none, 1 hold with SCK low, 2 hold with SCK high, 3 hold while disabled
    task automatic bit_x(input logic b, output logic r, output logic oe, input int kind);
        if (kind == 1) begin
            hold_n = 1'b0;
            waith();
            chk("R9 oe while paused", so_oe, 0);
            pulses();
            hold_n = 1'b1;
            waith();
        end
        if (kind == 3) begin
            hold_n = 1'b0;
            waith();
            chk("R11 oe with hold off", so_oe, 1);
            hold_n = 1'b1;
            waith();
        end
        si = b;
        waith();
        r  = so;
        oe = so_oe;
        sck = 1'b1;
        waith();
        if (kind == 2) begin
            hold_n = 1'b0;
            waith();
            chk("R10 oe after hold in high phase", so_oe, 0);
            sck = 1'b0;
            waith();
            pulses();
            hold_n = 1'b1;
            waith();
        end else begin
            sck = 1'b0;
        end
    endtask

    task automatic xbyte(input logic [7:0] d, output logic [7:0] r, output logic oe_all,
                         input int hb, input int kind);
        logic rb, ob;
        oe_all = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            bit_x(d[i], rb, ob, (i == hb) ? kind : 0);
            r[i] = rb;
            oe_all = oe_all & ob;
        end
    endtask

    task automatic begin_frame();
        cs_n = 1'b0;
        waith();
    endtask

    task automatic end_frame();
        waith();
        cs_n = 1'b1;
        repeat (3 * HALF) @(negedge clk);
    endtask

    task automatic set_status(input logic [7:0] v);
        logic [7:0] r;
        logic o;
        begin_frame();
        xbyte(8'h01, r, o, -1, 0);
        xbyte(v, r, o, -1, 0);
        end_frame();
        stat_m = {v[7:6], 5'b00000, v[0]};
    endtask

    task automatic rdsr_chk(input string tag);
        logic [7:0] r;
        logic o;
        begin_frame();
        xbyte(8'h05, r, o, -1, 0);
        xbyte(8'h00, r, o, -1, 0);
        chk(tag, {23'd0, o, r}, {23'd0, 1'b1, stat_m});
        xbyte(8'h00, r, o, -1, 0);
        chk({tag, " repeat"}, r, stat_m);
        end_frame();
    endtask

    task automatic wr_frame(input logic [15:0] a, input int n, input int hbyte,
                            input int hb, input int kind);
        logic [7:0] r;
        logic o;
        logic [14:0] p;
        begin_frame();
        xbyte(8'h02, r, o, -1, 0);
        xbyte(a[15:8], r, o, -1, 0);
        xbyte(a[7:0], r, o, -1, 0);
        p = a[14:0];
        for (int k = 0; k < n; k++) begin
            xbyte(wbuf[k], r, o, (k == hbyte) ? hb : -1, kind);
            if (mmode() != 0 || k == 0) mem_m[p[MEM_AW-1:0]] = wbuf[k];
            p = nxt(p);
        end
        end_frame();
    endtask

    task automatic rd_chk(input logic [15:0] a, input int n, input string tag,
                          input int hbyte, input int hb, input int kind);
        logic [7:0] r, e;
        logic o;
        logic [14:0] p;
        begin_frame();
        xbyte(8'h03, r, o, -1, 0);
        xbyte(a[15:8], r, o, -1, 0);
        xbyte(a[7:0], r, o, -1, 0);
        p = a[14:0];
        for (int k = 0; k < n; k++) begin
            xbyte(8'h00, r, o, (k == hbyte) ? hb : -1, kind);
            e = (mmode() == 0 && k > 0) ? 8'h00 : mem_m[p[MEM_AW-1:0]];
            chk(tag, r, e);
            if (k == 0) chk({tag, " oe"}, o, 1);
            p = nxt(p);
        end
        end_frame();
        chk("R8 oe after frame", so_oe, 0);
    endtask

    task automatic fill_rand(input int n);
        for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] r;
        logic o, oe_any;
        void'($urandom(32'd1357));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R8 oe after reset", so_oe, 0);
        rdsr_chk("R3 reset status");

        // prefill the whole storage window in burst mode
        set_status(8'h40);
        for (int blk = 0; blk < MEMN / 64; blk++) begin
            fill_rand(64);
            wr_frame(16'(blk * 64), 64, -1, -1, 0);
        end
        rd_chk(16'h0000, 8, "R2 burst readback", -1, -1, 0);
        rd_chk(16'h8010, 4, "R1 top bit ignored", -1, -1, 0);

        // word mode
        set_status(8'h00);
        fill_rand(3);
        wr_frame(16'h0020, 3, -1, -1, 0);
        rd_chk(16'h0020, 3, "R4 word read", -1, -1, 0);
        set_status(8'h40);
        rd_chk(16'h0020, 3, "R4 neighbours untouched", -1, -1, 0);

        // page mode wrap
        set_status(8'h80);
        rdsr_chk("R3 page code");
        fill_rand(4);
        wr_frame(16'h003E, 4, -1, -1, 0);
        rd_chk(16'h003F, 3, "R5 page read wrap", -1, -1, 0);
        set_status(8'h40);
        rd_chk(16'h003E, 4, "R5 outside page", -1, -1, 0);
        rd_chk(16'h0020, 2, "R5 page start", -1, -1, 0);

        // burst wrap at the top of the space
        fill_rand(4);
        wr_frame(16'h7FFE, 4, -1, -1, 0);
        rd_chk(16'h7FFF, 3, "R6 burst wrap", -1, -1, 0);
        rd_chk(16'h0000, 2, "R6 wrapped bytes", -1, -1, 0);

        // reserved mode code 11
        set_status(8'hC0);
        rdsr_chk("R7 code stored");
        fill_rand(2);
        wr_frame(16'h0040, 2, -1, -1, 0);
        rd_chk(16'h0040, 2, "R7 acts as word", -1, -1, 0);
        set_status(8'hFF);
        rdsr_chk("R3 reserved bits zero");
        set_status(8'h40);
        rd_chk(16'h0041, 1, "R7 second byte untouched", -1, -1, 0);

        // aborted write byte
        begin_frame();
        xbyte(8'h02, r, o, -1, 0);
        xbyte(8'h00, r, o, -1, 0);
        xbyte(8'h50, r, o, -1, 0);
        for (int i = 0; i < 4; i++) bit_x(~mem_m[8'h50][7 - i], r[0], o, 0);
        end_frame();
        chk("R8 oe after abort", so_oe, 0);
        rd_chk(16'h0050, 1, "R8 partial byte dropped", -1, -1, 0);

        // unknown opcode
        begin_frame();
        xbyte(8'hA5, r, o, -1, 0);
        oe_any = 1'b0;
        for (int k = 0; k < 4; k++) begin
            xbyte((k == 0) ? 8'h02 : (k == 2) ? 8'h60 : 8'h5A, r, o, -1, 0);
            for (int i = 0; i < 8; i++) ;
            oe_any = oe_any | o;
        end
        end_frame();
        chk("R12 so released", oe_any, 0);
        rd_chk(16'h0060, 1, "R12 memory untouched", -1, -1, 0);

        // hold with SCK low
        rd_chk(16'h0080, 3, "R9 read through hold", 1, 5, 1);
        fill_rand(3);
        wr_frame(16'h0090, 3, 1, 2, 1);
        rd_chk(16'h0090, 3, "R9 write through hold", -1, -1, 0);

        // hold with SCK high
        rd_chk(16'h0100, 3, "R10 read through hold", 1, 3, 2);
        fill_rand(3);
        wr_frame(16'h0110, 3, 2, 6, 2);
        rd_chk(16'h0110, 3, "R10 write through hold", -1, -1, 0);

        // hold disabled
        set_status(8'h41);
        rd_chk(16'h0180, 3, "R11 hold ignored", 1, 4, 3);
        set_status(8'h40);

        // random transactions
        for (int t = 0; t < 24; t++) begin
            logic [7:0] code;
            logic [15:0] a;
            int n;
            string tg;
            case ($urandom % 4)
                0: code = 8'h00;
                1: code = 8'h80;
                2: code = 8'h40;
                default: code = 8'hC0;
            endcase
            set_status(code);
            a = 16'($urandom);
            n = 1 + ($urandom % 16);
            case (code)
                8'h00: tg = "R4 random";
                8'h80: tg = "R5 random";
                8'h40: tg = "R6 random";
                default: tg = "R7 random";
            endcase
            if ($urandom % 2 == 1) begin
                fill_rand(n);
                wr_frame(a, n, -1, -1, 0);
                set_status(8'h40);
                rd_chk(a, n + 1, {tg, " write"}, -1, -1, 0);
            end else begin
                rd_chk(a, n, {tg, " read"}, -1, -1, 0);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule